// File: doc/BRIEF.md
# Serial-Controlled Channel Select Register

This block is the digital control core of an eight-way switch selector. A host talks to it over three wires: a serial clock, a select line and a data line. While the select line is high, four-bit control words are shifted in from the first data pin. Each word carries an enable flag followed by a three-bit channel number. When the select line falls, the captured word is applied to an eight-bit switch-enable output. The block first turns every switch off and only then turns on the new one, so two switches are never on together.

The same shift register also acts as a chain link. While select is high, the oldest bit in the register is driven out on the second data pin, so several selectors can share one serial port, each holding the last four bits that reached it. While select is low, the direction reverses: the second data pin becomes an input and is copied straight onto the first data pin with no clock delay, so a converter further down the chain can send its result back to the host. All serial inputs are asynchronous to the system clock. They pass through two-flop synchronisers, and the switch delays are counted in system-clock cycles.

Top module: `chain_chsel_ctrl`

## Requirements
- R1: While reset is asserted, and after reset until select has first been seen high, the switch enables are all 0 and neither data pin output-enable is asserted.
- R2: While select is high, each rising serial-clock edge shifts the first data pin's bit into the four-bit register, and the register changes at no other time.
- R3: A word is sent enable flag first, then channel bits from most to least significant. When the flag is 1, exactly bit N of the switch-enable output is set, where N is the three-bit channel number (0 to 7).
- R4: When the enable flag of the applied word is 0, all eight switch enables are 0.
- R5: Counting system-clock edges after the select input goes low, the switch enables are 0 from edge 3 through edge 2+T_OFF+T_ON. The new value appears at edge 3+T_OFF+T_ON. The enables never change directly from one nonzero value to a different nonzero value.
- R6: Shifting a new word while select is high does not change the switch enables that are currently applied.
- R7: While select is high, the second data pin is driven (its output-enable is 1 and the first pin's is 0) with the register's oldest bit. After four shifts it therefore carries the first bit sent, which is the enable flag.
- R8: If more than four bits are shifted, the last four form the word. The earlier bits come out on the second data pin in the order they were sent, one per shift.
- R9: While select is low, and once select has been high since reset, the first data pin is driven (its output-enable is 1 and the second pin's is 0) with the second pin's input value, combinationally.
- R10: The two data pin output-enables are never asserted together.
- R11: Serial-clock edges that occur while select is low leave the register unchanged.
- R12: A select falling edge that arrives while an earlier break-before-make sequence is still counting restarts the sequence. Timing is then measured from the newer edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for synchronising and delay counting |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk_i | input | 1 | Serial clock, asynchronous |
| csel_i | input | 1 | Select line, asynchronous; high = load/forward, low = apply/return |
| d1_i | input | 1 | First data pin, input value |
| d1_o | output | 1 | First data pin, driven value (return path) |
| d1_oe_o | output | 1 | First data pin output-enable |
| d2_i | input | 1 | Second data pin, input value |
| d2_o | output | 1 | Second data pin, driven value (chain forward) |
| d2_oe_o | output | 1 | Second data pin output-enable |
| sw_en_o | output | NUM_CH | One-hot switch enables, all zero when off |

## Verification
The two functions that can meet in the same cycle are the break-before-make sequencer, which is still counting its drain or settle window, and a new select falling edge that requests a fresh application. The bench provokes this by pulsing select high for a few cycles inside the drain window of an earlier fall and then dropping it again. A correct design shows all switches off until exactly 3+T_OFF+T_ON edges after the later fall. A design that ignored the second edge would expose the word about eight cycles too early, and the zero-hold check at the later edge would report it.

// File: rtl/chain_chsel_pkg.sv
package chain_chsel_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_DRAIN  = 2'd1,
    SEQ_SETTLE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/chain_chsel_sync.sv
module chain_chsel_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic stg1_q, stg2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg1_q <= 1'b0;
        stg2_q <= 1'b0;
      end else begin
        stg1_q <= async_i[g];
        stg2_q <= stg1_q;
      end
    end
    assign sync_o[g] = stg2_q;
  end
endmodule

// File: rtl/chain_chsel_shift.sv
module chain_chsel_shift #(
  parameter int WORD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr_q, sr_n;

  always_comb begin
    sr_n = sr_q;
    if (shift_en_i) sr_n = {sr_q[WORD_W-2:0], bit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_n;
  end

  assign word_o = sr_q;
endmodule

// File: rtl/chain_chsel_seq.sv
module chain_chsel_seq
  import chain_chsel_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SEL_W  = $clog2(NUM_CH),
  parameter int T_ON   = 10,
  parameter int T_OFF  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SEL_W:0]    word_i,
  output logic [NUM_CH-1:0] sw_en_o
);
  localparam int MAX_T = (T_ON > T_OFF) ? T_ON : T_OFF;
  localparam int CNT_W = $clog2(MAX_T + 1);

  seq_state_e        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [SEL_W:0]    pend_q, pend_n;
  logic [NUM_CH-1:0] sw_q, sw_n, dec;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      dec[i] = pend_q[SEL_W] && (pend_q[SEL_W-1:0] == SEL_W'(i));
  end

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    pend_n  = pend_q;
    sw_n    = sw_q;
    if (start_i) begin
      pend_n  = word_i;
      state_n = SEQ_DRAIN;
      cnt_n   = CNT_W'(T_OFF - 1);
      sw_n    = '0;
    end else begin
      unique case (state_q)
        SEQ_DRAIN: begin
          if (cnt_q == '0) begin
            state_n = SEQ_SETTLE;
            cnt_n   = CNT_W'(T_ON - 1);
          end else begin
            cnt_n = cnt_q - 1'b1;
          end
        end
        SEQ_SETTLE: begin
          if (cnt_q == '0) begin
            state_n = SEQ_IDLE;
            sw_n    = dec;
          end else begin
            cnt_n = cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      pend_q  <= '0;
      sw_q    <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      pend_q  <= pend_n;
      sw_q    <= sw_n;
    end
  end

  assign sw_en_o = sw_q;
endmodule

// File: rtl/chain_chsel_ctrl.sv
module chain_chsel_ctrl #(
  parameter int NUM_CH = 8,
  parameter int T_ON   = 10,
  parameter int T_OFF  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              csel_i,
  input  logic              d1_i,
  output logic              d1_o,
  output logic              d1_oe_o,
  input  logic              d2_i,
  output logic              d2_o,
  output logic              d2_oe_o,
  output logic [NUM_CH-1:0] sw_en_o
);
  localparam int SEL_W  = $clog2(NUM_CH);
  localparam int WORD_W = SEL_W + 1;

  logic rst_s1_q, rst_sn;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_sn   <= rst_s1_q;
    end
  end

  logic [2:0] in_sync;
  chain_chsel_sync #(.W(3)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sn),
    .async_i({d1_i, sclk_i, csel_i}),
    .sync_o (in_sync)
  );

  logic cs_s, sclk_s, d1_s;
  assign cs_s   = in_sync[0];
  assign sclk_s = in_sync[1];
  assign d1_s   = in_sync[2];

  logic cs_q, sclk_q, link_q, link_n;
  always_comb begin
    link_n = link_q;
    if (cs_s) link_n = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_sn) begin
    if (!rst_sn) begin
      cs_q   <= 1'b0;
      sclk_q <= 1'b0;
      link_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
      link_q <= link_n;
    end
  end

  logic cs_fall, sclk_rise;
  assign cs_fall   = cs_q & ~cs_s;
  assign sclk_rise = sclk_s & ~sclk_q;

  logic [WORD_W-1:0] word;
  chain_chsel_shift #(.WORD_W(WORD_W)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_sn),
    .shift_en_i(cs_s & sclk_rise),
    .bit_i     (d1_s),
    .word_o    (word)
  );

  chain_chsel_seq #(
    .NUM_CH(NUM_CH),
    .SEL_W (SEL_W),
    .T_ON  (T_ON),
    .T_OFF (T_OFF)
  ) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_sn),
    .start_i(cs_fall),
    .word_i (word),
    .sw_en_o(sw_en_o)
  );

  assign d2_o    = word[WORD_W-1];
  assign d2_oe_o = cs_s;
  assign d1_o    = d2_i;
  assign d1_oe_o = link_q & ~cs_s;
endmodule

// File: rtl/chain_chsel_ctrl_chk.sv
module chain_chsel_ctrl_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              d1_oe_o,
  input logic              d2_oe_o,
  input logic              d2_o,
  input logic              sclk_rise,
  input logic [NUM_CH-1:0] sw_en_o
);
  AST_OE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(d1_oe_o && d2_oe_o)); // R10

  AST_SW_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sw_en_o)); // R3

  AST_BREAK_BEFORE_MAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(sw_en_o) != '0) && (sw_en_o != '0)) |-> (sw_en_o == $past(sw_en_o))); // R5

  AST_SHIFT_ONLY_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(d2_oe_o) && d2_oe_o && !$past(sclk_rise)) |-> $stable(d2_o)); // R2
endmodule

bind chain_chsel_ctrl chain_chsel_ctrl_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .d1_oe_o  (d1_oe_o),
  .d2_oe_o  (d2_oe_o),
  .d2_o     (d2_o),
  .sclk_rise(sclk_rise),
  .sw_en_o  (sw_en_o)
);

// File: tb/test_chain_chsel_ctrl.sv
module test_chain_chsel_ctrl;
  localparam int NUM_CH = 8;
  localparam int T_ON   = 10;
  localparam int T_OFF  = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, csel = 1'b0, d1 = 1'b0, d2 = 1'b0;
  logic d1_o, d1_oe, d2_o, d2_oe;
  logic [NUM_CH-1:0] sw;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chain_chsel_ctrl #(.NUM_CH(NUM_CH), .T_ON(T_ON), .T_OFF(T_OFF)) i_chain_chsel_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .csel_i(csel),
    .d1_i(d1), .d1_o(d1_o), .d1_oe_o(d1_oe),
    .d2_i(d2), .d2_o(d2_o), .d2_oe_o(d2_oe), .sw_en_o(sw)
  );

  // {word[3:0] = EN,B2,B1,B0 ; expected one-hot}
  localparam logic [11:0] VEC [8] = '{
    {4'b1000, 8'h01}, {4'b1011, 8'h08}, {4'b1111, 8'h80}, {4'b0101, 8'h00},
    {4'b1110, 8'h40}, {4'b1100, 8'h10}, {4'b0000, 8'h00}, {4'b1001, 8'h02}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cs_up();
    @(negedge clk); csel = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    d1 = b;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic drop_check(input logic [7:0] exp, input string req);
    @(negedge clk); csel = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 off at edge 3", sw, 8'h00);
    repeat (T_OFF + T_ON - 1) @(negedge clk);
    chk("R5 still off at last gap edge", sw, 8'h00);
    @(negedge clk);
    chk(req, sw, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    repeat (3) @(negedge clk);
    chk("R1 sw during reset", sw, 8'h00);
    chk("R1 oe during reset", {d1_oe, d2_oe}, 2'b00);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 sw after reset", sw, 8'h00);
    chk("R1 oe before first select", {d1_oe, d2_oe}, 2'b00);

    prev = 8'h00;
    for (int v = 0; v < 8; v++) begin
      cs_up();
      chk("R7 directions select high", {d1_oe, d2_oe}, 2'b01);
      for (int b = 3; b >= 0; b--) send_bit(VEC[v][8+b]);
      chk("R7 first bit on chain out", d2_o, VEC[v][11]);
      chk("R6 enables held while loading", sw, prev);
      drop_check(VEC[v][7:0], VEC[v][11] ? "R3 one-hot select" : "R4 disabled word");
      prev = VEC[v][7:0];
    end

    // R9 return path
    chk("R9 directions select low", {d1_oe, d2_oe}, 2'b10);
    d2 = 1'b1; #1;
    chk("R9 return copy 1", d1_o, 1'b1);
    d2 = 1'b0; #1;
    chk("R9 return copy 0", d1_o, 1'b0);

    // R8 six bits: 1,0 then 1,1,0,1 -> word 1101 -> ch5
    cs_up();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    chk("R8 chain bit 1", d2_o, 1'b1);
    send_bit(1'b0);
    chk("R8 chain bit 2", d2_o, 1'b0);
    send_bit(1'b1);
    chk("R8 chain bit 3", d2_o, 1'b1);
    drop_check(8'h20, "R8 last four bits win");

    // R11 serial clocks while select low: stored word 1101 has msb 1
    for (int k = 0; k < 4; k++) send_bit(1'b0);
    @(negedge clk); csel = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 register untouched by low-select clocks", d2_o, 1'b1);
    drop_check(8'h20, "R11 same word reapplied");

    // R12 restart inside drain window: load 1010 -> ch2
    cs_up();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    @(negedge clk); csel = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 off during first drain", sw, 8'h00);
    csel = 1'b1;
    repeat (3) @(negedge clk);
    csel = 1'b0;
    repeat (2 + T_OFF + T_ON) @(negedge clk);
    chk("R12 still off measured from later fall", sw, 8'h00);
    @(negedge clk);
    chk("R12 word applied after restart", sw, 8'h04);
    chk("R10 exclusive enables", {d1_oe, d2_oe}, 2'b10);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule